// File: doc/BRIEF.md
# Exception Entry Controller

This block works out how a processor enters a handler when an exception is raised. A request gives the kind of exception and the machine state that affects entry: the current program counter, whether the faulting instruction is in a branch delay slot, the bootstrap-vector bit, the exception-level flag, debug mode, the interrupt-vector bit and the refill flag. The coprocessor number is also given. One clock edge later the block presents the redirect address and the return address, plus a write enable for whichever of the three return registers is being loaded. It also presents the cause fields, the mode-flag set strobes and, where needed, a new status word.

Exceptions fall into three families. Ordinary exceptions vector through a base and an offset. Reset-class events (power-up reset, soft reset, non-maskable interrupt) go to the boot address and record an error return. Debug events go to the debug vector and record a debug return. Return from handlers and interrupt masking are handled elsewhere.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Kind encoding on `exc_kind`: 0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4 load address error, 5 store address error, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 14 watch, 15 machine check. These kinds are ordinary. Their cause codes are 0,1,2,3,4,4,6,7,8,9,10,11,12,13,23,24 respectively.
- R2: The ordinary base is 0xBFC00200 when `boot_vec` is 1 and 0x80000000 when it is 0. The offset is 0x180 unless R3 or R4 applies.
- R3: An interrupt with `cause_iv` set uses offset 0x200.
- R4: A TLB load or TLB store with `refill` set while `exl_now` is clear uses offset 0x000.
- R5: On ordinary entry, `ret_addr` is PC−4 and `cause_bd` is 1 when `in_delay` is set. Otherwise it is PC and `cause_bd` is 0. `epc_we` and `set_exl` pulse.
- R6: Kinds 16 reset, 17 soft reset and 18 NMI redirect to 0xBFC00000. They write the error return (PC−4 if in a delay slot), pulse `err_epc_we` and `set_erl`, and load `status_val`. `status_val` has bit 28 and bit 22 set, bit 2 set, and bit 20 added for soft reset or bit 19 added for NMI.
- R7: Only a reset (kind 16) pulses `tlb_rst`, with `rnd_idx` equal to TLB_ENTRIES−1.
- R8: Debug kinds are 19 single step, 20 debug interrupt, 21 instruction break, 22 breakpoint, 23 data store break and 24 data load break. They redirect to 0xBFC00480, pulse `dbg_epc_we` and `set_dm`, and set `dbg_cause` bit (kind−19). The return address is PC−4 in a delay slot, except single step, which always returns to PC.
- R9: An interrupt (kind 0) raised while `in_debug` is 1 is handled as a debug interrupt (kind 20).
- R10: Coprocessor unusable pulses `ce_we` with `ce_val` equal to `cop_num`.
- R11: Every accepted entry pulses `dly_clr` and `done` one cycle after the request.
- R12: Kinds 25 to 31 pulse `bad_kind` and raise no write enable, mode strobe or `done`.
- R13: Without a request, and in reset, every strobe output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Exception request strobe |
| exc_kind | input | 5 | Exception kind (R1, R6, R8) |
| cur_pc | input | 32 | PC of faulting instruction |
| in_delay | input | 1 | Instruction is in a delay slot |
| boot_vec | input | 1 | Bootstrap vector bit of status |
| exl_now | input | 1 | Exception level currently set |
| in_debug | input | 1 | Processor is in debug mode |
| cause_iv | input | 1 | Special interrupt vector bit |
| refill | input | 1 | TLB fault was a no-match refill |
| cop_num | input | 2 | Coprocessor number |
| done | output | 1 | Entry computed |
| bad_kind | output | 1 | Unknown kind requested |
| redirect_pc | output | 32 | Handler address |
| ret_addr | output | 32 | Return address to store |
| epc_we | output | 1 | Write normal return register |
| err_epc_we | output | 1 | Write error return register |
| dbg_epc_we | output | 1 | Write debug return register |
| cause_we | output | 1 | Write cause code and delay bit |
| cause_code | output | 5 | Cause code (cause bits 6:2) |
| cause_bd | output | 1 | Delay-slot bit (cause bit 31) |
| ce_we | output | 1 | Write coprocessor field |
| ce_val | output | 2 | Coprocessor field (cause bits 29:28) |
| set_exl | output | 1 | Set exception level |
| set_erl | output | 1 | Set error level |
| set_dm | output | 1 | Enter debug mode |
| dly_clr | output | 1 | Clear delay-slot state |
| status_ld | output | 1 | Load status word |
| status_val | output | 32 | Status word for reset-class entry |
| tlb_rst | output | 1 | Clear wired and watch, load random index |
| rnd_idx | output | 4 | Random index value |
| dbg_cause | output | 6 | One-hot debug cause bits |

## Verification
The bench goes after the offset choices. A design that ignored the exception-level flag would send a nested refill to offset 0x000 and loop through the refill handler. One that mixed up the interrupt-vector bit would miss the dedicated interrupt handler. Delay-slot cases check the PC−4 return for each family. They also check the single-step exception to that rule: getting it wrong makes single stepping re-run the branch forever. Interrupts taken in debug mode and unknown kinds are checked too: a wrong design would enter the normal handler from debug mode, or would corrupt the return registers.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int TLB_ENTRIES = 16,
  localparam int RW = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [4:0]  exc_kind,
  input  logic [31:0] cur_pc,
  input  logic        in_delay,
  input  logic        boot_vec,
  input  logic        exl_now,
  input  logic        in_debug,
  input  logic        cause_iv,
  input  logic        refill,
  input  logic [1:0]  cop_num,
  output logic        done,
  output logic        bad_kind,
  output logic [31:0] redirect_pc,
  output logic [31:0] ret_addr,
  output logic        epc_we,
  output logic        err_epc_we,
  output logic        dbg_epc_we,
  output logic        cause_we,
  output logic [4:0]  cause_code,
  output logic        cause_bd,
  output logic        ce_we,
  output logic [1:0]  ce_val,
  output logic        set_exl,
  output logic        set_erl,
  output logic        set_dm,
  output logic        dly_clr,
  output logic        status_ld,
  output logic [31:0] status_val,
  output logic        tlb_rst,
  output logic [RW-1:0] rnd_idx,
  output logic [5:0]  dbg_cause
);
  localparam logic [4:0] K_INT = 5'd0, K_TLBL = 5'd2, K_TLBS = 5'd3, K_CPU = 5'd11;
  localparam logic [4:0] K_RST = 5'd16, K_SRST = 5'd17, K_NMI = 5'd18;
  localparam logic [4:0] K_DSS = 5'd19, K_DINT = 5'd20, K_LAST = 5'd24;
  localparam logic [31:0] BOOT_VEC = 32'hBFC00000, DBG_VEC = 32'hBFC00480;

  logic [4:0]  kind;
  logic        ord, errk, dbgk, known;
  logic [4:0]  code;
  logic [31:0] base, offs, npc, ret;
  logic [31:0] st;
  logic [5:0]  dbits;

  assign kind  = (exc_kind == K_INT && in_debug) ? K_DINT : exc_kind;
  assign ord   = kind < K_RST;
  assign errk  = kind >= K_RST && kind <= K_NMI;
  assign dbgk  = kind >= K_DSS && kind <= K_LAST;
  assign known = ord || errk || dbgk;
  assign ret   = (in_delay && kind != K_DSS) ? cur_pc - 32'd4 : cur_pc;
  assign dbits = dbgk ? 6'(6'd1 << (kind - K_DSS)) : 6'd0;

  always_comb begin
    case (kind)
      5'd4, 5'd5: code = 5'd4;
      5'd14:      code = 5'd23;
      5'd15:      code = 5'd24;
      default:    code = kind;
    endcase
  end

  assign base = boot_vec ? 32'hBFC00200 : 32'h80000000;
  always_comb begin
    offs = 32'h180;
    if (kind == K_INT && cause_iv) offs = 32'h200;
    if ((kind == K_TLBL || kind == K_TLBS) && refill && !exl_now) offs = 32'h0;
  end

  assign npc = ord ? base + offs : (errk ? BOOT_VEC : DBG_VEC);

  always_comb begin
    st = 32'h0;
    st[28] = 1'b1;
    st[22] = 1'b1;
    st[2]  = 1'b1;
    st[20] = kind == K_SRST;
    st[19] = kind == K_NMI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;       bad_kind <= 1'b0;
      epc_we <= 1'b0;     err_epc_we <= 1'b0;  dbg_epc_we <= 1'b0;
      cause_we <= 1'b0;   ce_we <= 1'b0;
      set_exl <= 1'b0;    set_erl <= 1'b0;     set_dm <= 1'b0;
      dly_clr <= 1'b0;    status_ld <= 1'b0;   tlb_rst <= 1'b0;
      redirect_pc <= 32'h0; ret_addr <= 32'h0;
      cause_code <= 5'd0; cause_bd <= 1'b0;    ce_val <= 2'd0;
      status_val <= 32'h0; rnd_idx <= '0;      dbg_cause <= 6'd0;
    end else begin
      done       <= req && known;
      bad_kind   <= req && !known;
      epc_we     <= req && ord;
      cause_we   <= req && ord;
      set_exl    <= req && ord;
      ce_we      <= req && kind == K_CPU;
      err_epc_we <= req && errk;
      set_erl    <= req && errk;
      status_ld  <= req && errk;
      tlb_rst    <= req && kind == K_RST;
      dbg_epc_we <= req && dbgk;
      set_dm     <= req && dbgk;
      dly_clr    <= req && known;
      dbg_cause  <= req ? dbits : 6'd0;
      if (req && known) begin
        redirect_pc <= npc;
        ret_addr    <= ret;
        cause_code  <= code;
        cause_bd    <= in_delay;
        ce_val      <= cop_num;
        status_val  <= st;
        rnd_idx     <= RW'(TLB_ENTRIES - 1);
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [4:0]  exc_kind,
  input logic        in_debug,
  input logic        done,
  input logic        bad_kind,
  input logic [31:0] redirect_pc,
  input logic        epc_we,
  input logic        err_epc_we,
  input logic        dbg_epc_we,
  input logic        set_exl,
  input logic        set_erl,
  input logic        set_dm,
  input logic [5:0]  dbg_cause
);
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({epc_we, err_epc_we, dbg_epc_we}));

  p_bad_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind |-> !(done || epc_we || err_epc_we || dbg_epc_we || set_exl || set_erl || set_dm));

  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !(done || bad_kind || epc_we || err_epc_we || dbg_epc_we));

  p_ordinary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && exc_kind < 5'd16 && !(exc_kind == 5'd0 && in_debug)) |=> (epc_we && set_exl));

  p_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_epc_we |-> (redirect_pc == 32'hBFC00000 && set_erl));

  p_debug_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_epc_we |-> (redirect_pc == 32'hBFC00480 && $countones(dbg_cause) == 1));

  p_dbg_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && exc_kind == 5'd0 && in_debug) |=> (dbg_epc_we && dbg_cause == 6'b000010));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .exc_kind(exc_kind), .in_debug(in_debug),
  .done(done), .bad_kind(bad_kind), .redirect_pc(redirect_pc),
  .epc_we(epc_we), .err_epc_we(err_epc_we), .dbg_epc_we(dbg_epc_we),
  .set_exl(set_exl), .set_erl(set_erl), .set_dm(set_dm), .dbg_cause(dbg_cause)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req = 0, in_delay = 0, boot_vec = 0, exl_now = 0, in_debug = 0, cause_iv = 0, refill = 0;
  logic [4:0] exc_kind = 0;
  logic [31:0] cur_pc = 0;
  logic [1:0] cop_num = 0;
  logic done, bad_kind, epc_we, err_epc_we, dbg_epc_we, cause_we, cause_bd, ce_we;
  logic set_exl, set_erl, set_dm, dly_clr, status_ld, tlb_rst;
  logic [31:0] redirect_pc, ret_addr, status_val;
  logic [4:0] cause_code;
  logic [1:0] ce_val;
  logic [3:0] rnd_idx;
  logic [5:0] dbg_cause;

  exc_entry_ctrl u0 (.*);

  int total = 0, bad = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [4:0]  k;
    logic [31:0] pc;
    logic dly, bev, exl, dbg, iv, rf;
    logic [31:0] npc, ret;
    logic [1:0]  sel;
    logic [4:0]  code;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{5'd8,  32'h1000, 0,0,0,0,0,0, 32'h80000180, 32'h1000, 2'd1, 5'd8},
    '{5'd8,  32'h1000, 1,1,0,0,0,0, 32'hBFC00380, 32'h0FFC, 2'd1, 5'd8},
    '{5'd0,  32'h1100, 0,0,0,0,1,0, 32'h80000200, 32'h1100, 2'd1, 5'd0},
    '{5'd0,  32'h1100, 0,0,0,0,0,0, 32'h80000180, 32'h1100, 2'd1, 5'd0},
    '{5'd0,  32'h1100, 0,1,0,0,1,0, 32'hBFC00400, 32'h1100, 2'd1, 5'd0},
    '{5'd2,  32'h1200, 0,0,0,0,0,1, 32'h80000000, 32'h1200, 2'd1, 5'd2},
    '{5'd2,  32'h1200, 0,0,1,0,0,1, 32'h80000180, 32'h1200, 2'd1, 5'd2},
    '{5'd3,  32'h1300, 0,1,0,0,0,1, 32'hBFC00200, 32'h1300, 2'd1, 5'd3},
    '{5'd3,  32'h1300, 0,0,0,0,0,0, 32'h80000180, 32'h1300, 2'd1, 5'd3},
    '{5'd8,  32'h1400, 0,0,0,0,0,1, 32'h80000180, 32'h1400, 2'd1, 5'd8},
    '{5'd1,  32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd1},
    '{5'd4,  32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd4},
    '{5'd5,  32'h1500, 1,0,0,0,0,0, 32'h80000180, 32'h14FC, 2'd1, 5'd4},
    '{5'd6,  32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd6},
    '{5'd7,  32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd7},
    '{5'd9,  32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd9},
    '{5'd10, 32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd10},
    '{5'd12, 32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd12},
    '{5'd13, 32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd13},
    '{5'd14, 32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd23},
    '{5'd15, 32'h1500, 0,0,0,0,0,0, 32'h80000180, 32'h1500, 2'd1, 5'd24},
    '{5'd16, 32'h2000, 1,0,0,0,0,0, 32'hBFC00000, 32'h1FFC, 2'd2, 5'd0},
    '{5'd18, 32'h2000, 0,0,0,0,0,0, 32'hBFC00000, 32'h2000, 2'd2, 5'd0},
    '{5'd19, 32'h3000, 1,0,0,1,0,0, 32'hBFC00480, 32'h3000, 2'd3, 5'd0},
    '{5'd22, 32'h3000, 1,0,0,0,0,0, 32'hBFC00480, 32'h2FFC, 2'd3, 5'd0},
    '{5'd0,  32'h3000, 1,0,0,1,1,0, 32'hBFC00480, 32'h2FFC, 2'd3, 5'd0}
  };

  task automatic fire(input logic [4:0] k, input logic [31:0] pc, input logic dly,
                      input logic bev, input logic exl, input logic dbg,
                      input logic iv, input logic rf, input logic [1:0] cop);
    @(negedge clk);
    req = 1; exc_kind = k; cur_pc = pc; in_delay = dly; boot_vec = bev;
    exl_now = exl; in_debug = dbg; cause_iv = iv; refill = rf; cop_num = cop;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset done", 32'(done), 0);
    chk("R13 reset strobes", 32'({epc_we, err_epc_we, dbg_epc_we, set_exl, set_erl, set_dm, tlb_rst}), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      fire(VT[i].k, VT[i].pc, VT[i].dly, VT[i].bev, VT[i].exl, VT[i].dbg, VT[i].iv, VT[i].rf, 2'd0);
      chk($sformatf("R2 R3 R4 R6 R8 R9 vec%0d pc", i), redirect_pc, VT[i].npc);
      chk($sformatf("R5 R6 R8 vec%0d ret", i), ret_addr, VT[i].ret);
      chk($sformatf("R11 vec%0d done", i), 32'({done, dly_clr}), 32'h3);
      chk($sformatf("R5 R6 R8 vec%0d sel", i), 32'({dbg_epc_we, err_epc_we, epc_we}),
          32'(3'b1 << (VT[i].sel - 2'd1)));
      if (VT[i].sel == 2'd1) begin
        chk($sformatf("R1 vec%0d code", i), 32'(cause_code), 32'(VT[i].code));
        chk($sformatf("R5 vec%0d bd", i), 32'({cause_we, set_exl, cause_bd}), 32'({2'b11, VT[i].dly}));
      end
    end

    fire(5'd16, 32'h4000, 0,0,0,0,0,0, 2'd0);
    chk("R6 reset status", status_val, 32'h10400004);
    chk("R7 reset tlb", 32'({tlb_rst, status_ld, set_erl}), 32'h7);
    chk("R7 rnd idx", 32'(rnd_idx), 32'd15);
    fire(5'd17, 32'h4000, 0,0,0,0,0,0, 2'd0);
    chk("R6 soft status", status_val, 32'h10500004);
    chk("R7 soft no tlb", 32'(tlb_rst), 0);
    fire(5'd18, 32'h4000, 0,0,0,0,0,0, 2'd0);
    chk("R6 nmi status", status_val, 32'h10480004);

    fire(5'd19, 32'h5000, 1,0,0,0,0,0, 2'd0);
    chk("R8 dss bits", 32'({set_dm, dbg_cause}), 32'h41);
    fire(5'd24, 32'h5000, 0,0,0,0,0,0, 2'd0);
    chk("R8 ddbl bits", 32'(dbg_cause), 32'h20);
    fire(5'd0, 32'h5000, 0,0,0,1,0,0, 2'd0);
    chk("R9 dint bits", 32'({epc_we, dbg_cause}), 32'h02);

    fire(5'd11, 32'h6000, 0,0,0,0,0,0, 2'd2);
    chk("R10 ce", 32'({ce_we, ce_val}), 32'h6);
    chk("R1 cpu code", 32'(cause_code), 32'd11);
    fire(5'd8, 32'h6000, 0,0,0,0,0,0, 2'd3);
    chk("R10 no ce", 32'(ce_we), 0);

    fire(5'd8, 32'h7000, 0,0,0,0,0,0, 2'd0);
    fire(5'd27, 32'h7100, 1,0,0,0,0,0, 2'd0);
    chk("R12 bad flag", 32'({bad_kind, done}), 32'h2);
    chk("R12 no writes", 32'({epc_we, err_epc_we, dbg_epc_we, set_exl, set_erl, set_dm, dly_clr}), 0);
    chk("R12 ret kept", ret_addr, 32'h7000);
    @(negedge clk);
    chk("R13 idle", 32'({done, bad_kind, epc_we, dly_clr}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule